// File: doc/BRIEF.md
# Directory-Coherent Cache Line Controller

This block is the processor-side controller of one cache in a system where coherence is kept by a home directory rather than by snooping a shared bus. It holds a small direct-mapped cache. Each line carries a tag, a data line of several words and one of three states: Invalid, Shared (read-only) or Exclusive (read/write). Processor reads and writes that hit complete in the cycle they are presented. On a miss, the controller sends an explicit request message to the home directory and holds the processor until the directory's data reply arrives. Write data is merged into the returned line before the processor is released.

The directory can also address the cache with an invalidate, a fetch or a fetch-and-invalidate for a block. The controller serves these at once. A fetch that finds the block Exclusive returns the whole line as a write-back message in the same cycle. When a miss evicts an Exclusive line of another block, the victim's write-back goes out one cycle before the miss request.

The sequencing state machine has four states. IDLE serves hits and detects misses. VICTIM sends the evicted line's write-back. MISS sends the read-miss or write-miss request. WAIT holds until the data reply. The transitions are:
- IDLE→VICTIM on a miss that evicts an Exclusive line of another block.
- IDLE→MISS on any other miss, including a write to a Shared line.
- VICTIM→MISS after the write-back is sent.
- MISS→WAIT after the request is sent.
- WAIT→IDLE when the reply arrives.

A directory request in the same cycle holds the machine in its state. The processor keeps its request and fields stable until `cpu_done`.

Top module: `coh_cache_ctrl`

## Requirements
- R1: While reset is asserted and right after it, no message is sent and no access completes; every line starts Invalid, so the first access to any address is a miss.
- R2: A read that misses sends a read miss (msg_kind 0, msg_addr = block address cpu_addr[9:2], msg_data 0) one cycle after it is presented. It then stalls (cpu_stall high, cpu_done low) until a data reply (dir_kind 3) arrives. It completes in the reply cycle with the addressed word of the reply, and the line becomes Shared.
- R3: A write to an Invalid line sends a write miss (msg_kind 1) and completes on the reply, leaving the line Exclusive; later reads and writes to it hit.
- R4: A write to a Shared line sends a write miss and leaves the line Exclusive.
- R5: Read hits in Shared or Exclusive and write hits in Exclusive send no message and assert cpu_done in the cycle the request is presented.
- R6: An invalidate (dir_kind 0) to a resident block sends no message and makes the line Invalid.
- R7: A fetch (dir_kind 1) to an Exclusive block sends, in the same cycle, a write-back (msg_kind 2) with the directory's address and the full line, and the line becomes Shared.
- R8: A fetch-and-invalidate (dir_kind 2) to an Exclusive block sends the same write-back and makes the line Invalid.
- R9: A miss that evicts an Exclusive line of another block first sends that line's write-back (victim address and data), then the miss request in the next cycle.
- R10: A miss that evicts a Shared line sends only the miss request.
- R11: On a write miss, the written word replaces word cpu_addr[1:0] of the reply line (word 0 in bits 7:0); the other words keep the reply data.
- R12: Directory requests to a block that is not resident, and fetches to a Shared line, send nothing and leave the line unchanged.
- R13: A directory request presented in the same cycle as a processor access is served first; the access does not complete in that cycle and completes afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor access request, held until cpu_done |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 10 | Word address: tag [9:4], index [3:2], word [1:0] |
| cpu_wdata | input | 8 | Write word |
| cpu_stall | output | 1 | Processor must wait |
| cpu_done | output | 1 | Access completes this cycle |
| cpu_rdata | output | 8 | Word value after the access, valid with cpu_done |
| dir_valid | input | 1 | Directory message present |
| dir_kind | input | 2 | 0 invalidate, 1 fetch, 2 fetch-and-invalidate, 3 data reply |
| dir_addr | input | 8 | Block address of the request |
| dir_data | input | 32 | Line data of a data reply |
| msg_valid | output | 1 | Outgoing message present |
| msg_kind | output | 2 | 0 read miss, 1 write miss, 2 write-back |
| msg_addr | output | 8 | Block address |
| msg_data | output | 32 | Line data for a write-back, else 0 |

## Verification
The hardest case to reach is the eviction of an Exclusive line. The same index must first be brought to Exclusive under one tag, through a Shared-line replacement with a write miss. Then a read to a different tag must hit that index. The bench builds this chain step by step and then checks that the victim write-back and the read miss arrive in that order in consecutive cycles. The collision of a directory fetch with a processor hit is forced by driving both in the same cycle. The bench then checks that the write-back appears, the access completes one cycle later, and a following write now needs an upgrade miss.

// File: rtl/coh_pkg.sv
package coh_pkg;

    typedef enum logic [1:0] {
        LN_INV = 2'd0,
        LN_SHR = 2'd1,
        LN_EXC = 2'd2
    } line_st_e;

    typedef enum logic [1:0] {
        OUT_RD_MISS = 2'd0,
        OUT_WR_MISS = 2'd1,
        OUT_WRBACK  = 2'd2
    } out_kind_e;

    typedef enum logic [1:0] {
        IN_INVAL     = 2'd0,
        IN_FETCH     = 2'd1,
        IN_FETCH_INV = 2'd2,
        IN_REPLY     = 2'd3
    } in_kind_e;

    typedef enum logic [1:0] {
        FS_IDLE   = 2'd0,
        FS_VICTIM = 2'd1,
        FS_MISS   = 2'd2,
        FS_WAIT   = 2'd3
    } fsm_st_e;

endpackage

// File: rtl/coh_line_store.sv
module coh_line_store
    import coh_pkg::*;
#(
    parameter int IDX_W  = 2,
    parameter int TAG_W  = 6,
    parameter int LINE_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  a_idx,
    output line_st_e          a_st,
    output logic [TAG_W-1:0]  a_tag,
    output logic [LINE_W-1:0] a_data,
    input  logic [IDX_W-1:0]  b_idx,
    output line_st_e          b_st,
    output logic [TAG_W-1:0]  b_tag,
    output logic [LINE_W-1:0] b_data,
    input  logic              we,
    input  logic [IDX_W-1:0]  w_idx,
    input  line_st_e          w_st,
    input  logic [TAG_W-1:0]  w_tag,
    input  logic [LINE_W-1:0] w_data
);
    localparam int LINES = 1 << IDX_W;

    line_st_e          st_q  [LINES];
    logic [TAG_W-1:0]  tag_q [LINES];
    logic [LINE_W-1:0] dat_q [LINES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) begin
                st_q[i]  <= LN_INV;
                tag_q[i] <= '0;
                dat_q[i] <= '0;
            end
        end else if (we) begin
            st_q[w_idx]  <= w_st;
            tag_q[w_idx] <= w_tag;
            dat_q[w_idx] <= w_data;
        end
    end

    assign a_st   = st_q[a_idx];
    assign a_tag  = tag_q[a_idx];
    assign a_data = dat_q[a_idx];
    assign b_st   = st_q[b_idx];
    assign b_tag  = tag_q[b_idx];
    assign b_data = dat_q[b_idx];

endmodule

// File: rtl/coh_probe_unit.sv
module coh_probe_unit
    import coh_pkg::*;
#(
    parameter int TAG_W = 6
) (
    input  logic             dir_valid,
    input  logic [1:0]       dir_kind,
    input  logic [TAG_W-1:0] dir_tag,
    input  line_st_e         ln_st,
    input  logic [TAG_W-1:0] ln_tag,
    output logic             take,
    output logic             upd,
    output line_st_e         new_st,
    output logic             wb
);
    logic hit;

    always_comb begin
        take   = dir_valid && (dir_kind != IN_REPLY);
        hit    = (ln_st != LN_INV) && (ln_tag == dir_tag);
        upd    = 1'b0;
        new_st = ln_st;
        wb     = 1'b0;
        if (take && hit) begin
            unique case (in_kind_e'(dir_kind))
                IN_INVAL: begin
                    upd    = 1'b1;
                    new_st = LN_INV;
                end
                IN_FETCH: begin
                    if (ln_st == LN_EXC) begin
                        upd    = 1'b1;
                        new_st = LN_SHR;
                        wb     = 1'b1;
                    end
                end
                IN_FETCH_INV: begin
                    upd    = 1'b1;
                    new_st = LN_INV;
                    wb     = (ln_st == LN_EXC);
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/coh_ctrl_fsm.sv
module coh_ctrl_fsm
    import coh_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int IDX_W  = 2,
    parameter int OFF_W  = 2,
    parameter int WORD_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cpu_req,
    input  logic                      cpu_we,
    input  logic [ADDR_W-1:0]         cpu_addr,
    input  logic [WORD_W-1:0]         cpu_wdata,
    input  logic                      probe_take,
    input  logic                      reply_valid,
    input  logic [(WORD_W<<OFF_W)-1:0] reply_data,
    input  line_st_e                  ln_st,
    input  logic [ADDR_W-OFF_W-IDX_W-1:0] ln_tag,
    input  logic [(WORD_W<<OFF_W)-1:0] ln_data,
    output fsm_st_e                   st_q,
    output logic                      done,
    output logic [WORD_W-1:0]         rdata,
    output logic                      m_valid,
    output logic [1:0]                m_kind,
    output logic [ADDR_W-OFF_W-1:0]   m_addr,
    output logic [(WORD_W<<OFF_W)-1:0] m_data,
    output logic                      w_en,
    output line_st_e                  w_st,
    output logic [ADDR_W-OFF_W-IDX_W-1:0] w_tag,
    output logic [(WORD_W<<OFF_W)-1:0] w_data
);
    localparam int LINE_W = WORD_W << OFF_W;
    localparam int BLK_W  = ADDR_W - OFF_W;
    localparam int TAG_W  = BLK_W - IDX_W;

    fsm_st_e           st_d;
    logic              go_miss;
    logic [BLK_W-1:0]  vict_blk_q;
    logic [LINE_W-1:0] vict_data_q;

    logic [TAG_W-1:0]  req_tag;
    logic [IDX_W-1:0]  req_idx;
    logic [OFF_W-1:0]  req_off;
    logic [BLK_W-1:0]  req_blk;
    logic              tag_hit;
    logic              can_serve;

    assign req_tag   = cpu_addr[ADDR_W-1 -: TAG_W];
    assign req_idx   = cpu_addr[OFF_W +: IDX_W];
    assign req_off   = cpu_addr[OFF_W-1:0];
    assign req_blk   = cpu_addr[ADDR_W-1:OFF_W];
    assign tag_hit   = (ln_st != LN_INV) && (ln_tag == req_tag);
    assign can_serve = cpu_we ? (tag_hit && ln_st == LN_EXC) : tag_hit;

    function automatic logic [LINE_W-1:0] put_word(
        input logic [LINE_W-1:0] line,
        input logic [OFF_W-1:0]  off,
        input logic [WORD_W-1:0] w
    );
        logic [LINE_W-1:0] r;
        r = line;
        r[off*WORD_W +: WORD_W] = w;
        return r;
    endfunction

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= FS_IDLE;
        else        st_q <= st_d;
    end

    // Victim holding registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vict_blk_q  <= '0;
            vict_data_q <= '0;
        end else if (go_miss) begin
            vict_blk_q  <= {ln_tag, req_idx};
            vict_data_q <= ln_data;
        end
    end

    // Next state and outputs
    always_comb begin
        st_d    = st_q;
        go_miss = 1'b0;
        done    = 1'b0;
        rdata   = ln_data[req_off*WORD_W +: WORD_W];
        m_valid = 1'b0;
        m_kind  = OUT_RD_MISS;
        m_addr  = req_blk;
        m_data  = '0;
        w_en    = 1'b0;
        w_st    = ln_st;
        w_tag   = ln_tag;
        w_data  = ln_data;
        unique case (st_q)
            FS_IDLE: begin
                if (cpu_req && !probe_take) begin
                    if (can_serve) begin
                        done = 1'b1;
                        if (cpu_we) begin
                            rdata  = cpu_wdata;
                            w_en   = 1'b1;
                            w_data = put_word(ln_data, req_off, cpu_wdata);
                        end
                    end else begin
                        go_miss = 1'b1;
                        w_en    = 1'b1;
                        w_st    = LN_INV;
                        st_d    = (ln_st == LN_EXC && ln_tag != req_tag) ? FS_VICTIM : FS_MISS;
                    end
                end
            end
            FS_VICTIM: begin
                if (!probe_take) begin
                    m_valid = 1'b1;
                    m_kind  = OUT_WRBACK;
                    m_addr  = vict_blk_q;
                    m_data  = vict_data_q;
                    st_d    = FS_MISS;
                end
            end
            FS_MISS: begin
                if (!probe_take) begin
                    m_valid = 1'b1;
                    m_kind  = cpu_we ? OUT_WR_MISS : OUT_RD_MISS;
                    st_d    = FS_WAIT;
                end
            end
            FS_WAIT: begin
                if (reply_valid) begin
                    done  = 1'b1;
                    w_en  = 1'b1;
                    w_tag = req_tag;
                    if (cpu_we) begin
                        w_st   = LN_EXC;
                        w_data = put_word(reply_data, req_off, cpu_wdata);
                        rdata  = cpu_wdata;
                    end else begin
                        w_st   = LN_SHR;
                        w_data = reply_data;
                        rdata  = reply_data[req_off*WORD_W +: WORD_W];
                    end
                    st_d = FS_IDLE;
                end
            end
        endcase
    end

endmodule

// File: rtl/coh_cache_ctrl.sv
module coh_cache_ctrl
    import coh_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int IDX_W  = 2,
    parameter int OFF_W  = 2,
    parameter int WORD_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cpu_req,
    input  logic                       cpu_we,
    input  logic [ADDR_W-1:0]          cpu_addr,
    input  logic [WORD_W-1:0]          cpu_wdata,
    output logic                       cpu_stall,
    output logic                       cpu_done,
    output logic [WORD_W-1:0]          cpu_rdata,
    input  logic                       dir_valid,
    input  logic [1:0]                 dir_kind,
    input  logic [ADDR_W-OFF_W-1:0]    dir_addr,
    input  logic [(WORD_W<<OFF_W)-1:0] dir_data,
    output logic                       msg_valid,
    output logic [1:0]                 msg_kind,
    output logic [ADDR_W-OFF_W-1:0]    msg_addr,
    output logic [(WORD_W<<OFF_W)-1:0] msg_data
);
    localparam int LINE_W = WORD_W << OFF_W;
    localparam int BLK_W  = ADDR_W - OFF_W;
    localparam int TAG_W  = BLK_W - IDX_W;

    line_st_e          a_st, b_st;
    logic [TAG_W-1:0]  a_tag, b_tag;
    logic [LINE_W-1:0] a_data, b_data;

    logic              p_take, p_upd, p_wb;
    line_st_e          p_st;

    fsm_st_e           fsm_st;
    logic              f_valid, f_we;
    logic [1:0]        f_kind;
    logic [BLK_W-1:0]  f_addr;
    logic [LINE_W-1:0] f_data, f_wdata;
    line_st_e          f_wst;
    logic [TAG_W-1:0]  f_wtag;

    logic              s_we;
    logic [IDX_W-1:0]  s_idx;
    line_st_e          s_st;
    logic [TAG_W-1:0]  s_tag;
    logic [LINE_W-1:0] s_data;

    coh_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .a_idx  (cpu_addr[OFF_W +: IDX_W]),
        .a_st   (a_st),
        .a_tag  (a_tag),
        .a_data (a_data),
        .b_idx  (dir_addr[IDX_W-1:0]),
        .b_st   (b_st),
        .b_tag  (b_tag),
        .b_data (b_data),
        .we     (s_we),
        .w_idx  (s_idx),
        .w_st   (s_st),
        .w_tag  (s_tag),
        .w_data (s_data)
    );

    coh_probe_unit #(.TAG_W(TAG_W)) u_probe (
        .dir_valid (dir_valid),
        .dir_kind  (dir_kind),
        .dir_tag   (dir_addr[BLK_W-1:IDX_W]),
        .ln_st     (b_st),
        .ln_tag    (b_tag),
        .take      (p_take),
        .upd       (p_upd),
        .new_st    (p_st),
        .wb        (p_wb)
    );

    coh_ctrl_fsm #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .WORD_W(WORD_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cpu_req     (cpu_req),
        .cpu_we      (cpu_we),
        .cpu_addr    (cpu_addr),
        .cpu_wdata   (cpu_wdata),
        .probe_take  (p_take),
        .reply_valid (dir_valid && dir_kind == IN_REPLY),
        .reply_data  (dir_data),
        .ln_st       (a_st),
        .ln_tag      (a_tag),
        .ln_data     (a_data),
        .st_q        (fsm_st),
        .done        (cpu_done),
        .rdata       (cpu_rdata),
        .m_valid     (f_valid),
        .m_kind      (f_kind),
        .m_addr      (f_addr),
        .m_data      (f_data),
        .w_en        (f_we),
        .w_st        (f_wst),
        .w_tag       (f_wtag),
        .w_data      (f_wdata)
    );

    // Store write port: directory requests take precedence
    always_comb begin
        if (p_upd) begin
            s_we   = 1'b1;
            s_idx  = dir_addr[IDX_W-1:0];
            s_st   = p_st;
            s_tag  = b_tag;
            s_data = b_data;
        end else begin
            s_we   = f_we;
            s_idx  = cpu_addr[OFF_W +: IDX_W];
            s_st   = f_wst;
            s_tag  = f_wtag;
            s_data = f_wdata;
        end
    end

    // Outgoing message: probe write-back or sequencer message
    always_comb begin
        if (p_wb) begin
            msg_valid = 1'b1;
            msg_kind  = OUT_WRBACK;
            msg_addr  = dir_addr;
            msg_data  = b_data;
        end else begin
            msg_valid = f_valid;
            msg_kind  = f_kind;
            msg_addr  = f_addr;
            msg_data  = f_data;
        end
    end

    assign cpu_stall = cpu_req && !cpu_done;

endmodule

// File: rtl/coh_cache_ctrl_chk.sv
module coh_cache_ctrl_chk #(
    parameter int BLK_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cpu_req,
    input logic             cpu_stall,
    input logic             cpu_done,
    input logic             dir_valid,
    input logic [1:0]       dir_kind,
    input logic [BLK_W-1:0] dir_addr,
    input logic             msg_valid,
    input logic [1:0]       msg_kind,
    input logic [BLK_W-1:0] msg_addr
);
    p_quiet_in_reset_r1: assert property (@(posedge clk)
        !rst_n |-> (!msg_valid && !cpu_done));

    p_miss_while_stalled_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && (msg_kind == 2'd0 || msg_kind == 2'd1)) |-> (cpu_req && cpu_stall));

    p_done_only_on_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |-> cpu_req);

    p_inval_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_valid && dir_kind == 2'd0) |-> !msg_valid);

    p_probe_wb_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_kind == 2'd2 && dir_valid) |->
            (msg_addr == dir_addr && (dir_kind == 2'd1 || dir_kind == 2'd2)));

    p_victim_then_miss_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_kind == 2'd2 && !dir_valid) |=>
            (dir_valid || (msg_valid && msg_kind != 2'd2)));

    p_probe_first_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_valid && dir_kind != 2'd3) |-> !cpu_done);

endmodule

bind coh_cache_ctrl coh_cache_ctrl_chk #(.BLK_W(BLK_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_req   (cpu_req),
    .cpu_stall (cpu_stall),
    .cpu_done  (cpu_done),
    .dir_valid (dir_valid),
    .dir_kind  (dir_kind),
    .dir_addr  (dir_addr),
    .msg_valid (msg_valid),
    .msg_kind  (msg_kind),
    .msg_addr  (msg_addr)
);

// File: tb/coh_cache_ctrl_tb.sv
module coh_cache_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cpu_req, cpu_we;
    logic [9:0]  cpu_addr;
    logic [7:0]  cpu_wdata;
    logic        cpu_stall, cpu_done;
    logic [7:0]  cpu_rdata;
    logic        dir_valid;
    logic [1:0]  dir_kind;
    logic [7:0]  dir_addr;
    logic [31:0] dir_data;
    logic        msg_valid;
    logic [1:0]  msg_kind;
    logic [7:0]  msg_addr;
    logic [31:0] msg_data;

    always #2 clk = ~clk;

    coh_cache_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_stall(cpu_stall), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
        .dir_valid(dir_valid), .dir_kind(dir_kind), .dir_addr(dir_addr), .dir_data(dir_data),
        .msg_valid(msg_valid), .msg_kind(msg_kind), .msg_addr(msg_addr), .msg_data(msg_data)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    typedef struct packed {
        logic [1:0]  kind;
        logic [7:0]  addr;
        logic [31:0] data;
    } exp_msg_t;

    exp_msg_t exp_q[$];
    string    tag_q[$];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic expect_msg(input logic [1:0] kind, input logic [7:0] addr,
                              input logic [31:0] data, input string req);
        exp_q.push_back('{kind: kind, addr: addr, data: data});
        tag_q.push_back(req);
    endtask

    // Monitor: compare every outgoing message against the scoreboard
    always @(negedge clk) begin
        if (rst_n && msg_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R12", "unexpected message kind", {30'd0, msg_kind}, 32'hffffffff);
            end else begin
                exp_msg_t e;
                string    r;
                e = exp_q.pop_front();
                r = tag_q.pop_front();
                check(msg_kind == e.kind, r, "message kind", {30'd0, msg_kind}, {30'd0, e.kind});
                check(msg_addr == e.addr, r, "message address", {24'd0, msg_addr}, {24'd0, e.addr});
                check(msg_data == e.data, r, "message data", msg_data, e.data);
            end
        end
    end

    task automatic drained(input string req);
        check(exp_q.size() == 0, req, "expected messages outstanding", exp_q.size(), 0);
    endtask

    task automatic do_hit(input bit we, input logic [9:0] a, input logic [7:0] wd,
                          input logic [7:0] exp, input string req);
        @(posedge clk); #1;
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        @(negedge clk);
        check(cpu_done == 1'b1, req, "hit completes at once", {31'd0, cpu_done}, 1);
        check(cpu_rdata == exp, req, "hit data", {24'd0, cpu_rdata}, {24'd0, exp});
        @(posedge clk); #1;
        cpu_req = 1'b0;
        drained(req);
    endtask

    task automatic do_miss(input bit we, input logic [9:0] a, input logic [7:0] wd,
                           input logic [31:0] reply, input logic [7:0] exp, input string req);
        bit seen;
        seen = 1'b0;
        @(posedge clk); #1;
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        for (int n = 0; n < 8 && !seen; n++) begin
            @(negedge clk);
            if (cpu_done) check(1'b0, req, "completion before reply", 1, 0);
            if (msg_valid && msg_kind != 2'd2) seen = 1'b1;
        end
        check(seen, req, "miss request sent", {31'd0, seen}, 1);
        check(cpu_stall == 1'b1, req, "stalled while waiting", {31'd0, cpu_stall}, 1);
        @(posedge clk); #1;
        dir_valid = 1'b1; dir_kind = 2'd3; dir_data = reply; dir_addr = a[9:2];
        @(negedge clk);
        check(cpu_done == 1'b1, req, "completes on reply", {31'd0, cpu_done}, 1);
        check(cpu_rdata == exp, req, "data on reply", {24'd0, cpu_rdata}, {24'd0, exp});
        @(posedge clk); #1;
        dir_valid = 1'b0; cpu_req = 1'b0;
        drained(req);
    endtask

    task automatic do_probe(input logic [1:0] kind, input logic [7:0] blk, input string req);
        @(posedge clk); #1;
        dir_valid = 1'b1; dir_kind = kind; dir_addr = blk;
        @(negedge clk);
        @(posedge clk); #1;
        dir_valid = 1'b0;
        drained(req);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        #(4 * 50000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
        dir_valid = 1'b0; dir_kind = '0; dir_addr = '0; dir_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(msg_valid == 1'b0, "R1", "no message in reset", {31'd0, msg_valid}, 0);
        check(cpu_done == 1'b0, "R1", "no completion in reset", {31'd0, cpu_done}, 0);
        @(posedge clk); #1;
        rst_n = 1'b1;

        // R1 / R2: first read misses, line becomes Shared
        expect_msg(2'd0, 8'h05, 32'h0, "R2");
        do_miss(1'b0, 10'h014, 8'h00, 32'h44332211, 8'h11, "R2");
        do_hit(1'b0, 10'h017, 8'h00, 8'h44, "R5");

        // R4: write to Shared upgrades; R11 merge
        expect_msg(2'd1, 8'h05, 32'h0, "R4");
        do_miss(1'b1, 10'h015, 8'hAA, 32'h44332211, 8'hAA, "R4");
        do_hit(1'b0, 10'h016, 8'h00, 8'h33, "R11");
        do_hit(1'b0, 10'h015, 8'h00, 8'hAA, "R11");
        do_hit(1'b1, 10'h014, 8'h55, 8'h55, "R5");

        // R7: fetch on Exclusive -> write-back, Shared
        expect_msg(2'd2, 8'h05, 32'h4433AA55, "R7");
        do_probe(2'd1, 8'h05, "R7");
        do_hit(1'b0, 10'h014, 8'h00, 8'h55, "R7");
        expect_msg(2'd1, 8'h05, 32'h0, "R7");
        do_miss(1'b1, 10'h014, 8'h66, 32'h4433AA55, 8'h66, "R7");

        // R8: fetch-and-invalidate on Exclusive
        expect_msg(2'd2, 8'h05, 32'h4433AA66, "R8");
        do_probe(2'd2, 8'h05, "R8");
        expect_msg(2'd0, 8'h05, 32'h0, "R8");
        do_miss(1'b0, 10'h014, 8'h00, 32'h01020304, 8'h04, "R8");

        // R6: invalidate on Shared
        do_probe(2'd0, 8'h05, "R6");
        expect_msg(2'd0, 8'h05, 32'h0, "R6");
        do_miss(1'b0, 10'h014, 8'h00, 32'h0A0B0C0D, 8'h0D, "R6");

        // R12: requests with no effect
        do_probe(2'd1, 8'h05, "R12");
        do_probe(2'd2, 8'h15, "R12");
        do_probe(2'd0, 8'h02, "R12");
        do_hit(1'b0, 10'h014, 8'h00, 8'h0D, "R12");

        // R10: Shared victim replaced by a write
        expect_msg(2'd1, 8'h15, 32'h0, "R10");
        do_miss(1'b1, 10'h054, 8'h99, 32'h11111111, 8'h99, "R10");

        // R9: Exclusive victim write-back, then read miss
        expect_msg(2'd2, 8'h15, 32'h11111199, "R9");
        expect_msg(2'd0, 8'h05, 32'h0, "R9");
        do_miss(1'b0, 10'h014, 8'h00, 32'hDEADBEEF, 8'hEF, "R9");

        // R3: write to Invalid line
        expect_msg(2'd1, 8'h0F, 32'h0, "R3");
        do_miss(1'b1, 10'h03F, 8'h77, 32'h00000000, 8'h77, "R3");
        do_hit(1'b0, 10'h03F, 8'h00, 8'h77, "R3");
        do_hit(1'b0, 10'h03C, 8'h00, 8'h00, "R3");

        // R13: fetch collides with a read hit
        expect_msg(2'd2, 8'h0F, 32'h77000000, "R13");
        @(posedge clk); #1;
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 10'h03F;
        dir_valid = 1'b1; dir_kind = 2'd1; dir_addr = 8'h0F;
        @(negedge clk);
        check(cpu_done == 1'b0, "R13", "access deferred", {31'd0, cpu_done}, 0);
        @(posedge clk); #1;
        dir_valid = 1'b0;
        @(negedge clk);
        check(cpu_done == 1'b1, "R13", "access completes after", {31'd0, cpu_done}, 1);
        check(cpu_rdata == 8'h77, "R13", "deferred read data", {24'd0, cpu_rdata}, 32'h77);
        @(posedge clk); #1;
        cpu_req = 1'b0;
        drained("R13");
        expect_msg(2'd1, 8'h0F, 32'h0, "R13");
        do_miss(1'b1, 10'h03F, 8'h12, 32'h77000000, 8'h12, "R13");

        repeat (4) @(posedge clk);
        drained("R12");
        finished = 1'b1;
        summary();
        $finish;
    end

endmodule